// File: doc/BRIEF.md
# Full-Period Shift-Register Counter

This block is a Fibonacci shift-register counter that steps through every one of its 2^WIDTH states, the all-zero state included, before the sequence repeats. The core is a maximal-length linear feedback shift register. On its own such a register has only 2^WIDTH−1 states and would stay stuck at zero forever. A second term is XORed into the feedback. That term is true when every stage except the rightmost is zero, and it splices the zero state into the cycle right after the state whose only set bit is the rightmost one.

The counter is meant for pointers and terminal counters, where only the order of the states matters and not their binary value. Its logic depth is one wide NOR and a small XOR, whatever the width. The register shifts rightward and the new bit enters at the leftmost stage. The rightmost stage is also brought out as a serial bit stream. Any WIDTH consecutive samples of that stream form a window that occurs once per period, and over one period the windows take every WIDTH-bit value. A synchronous reset loads a fixed nonzero seed. A load input can place any value, including zero, and an enable gates the stepping.

Top module: `debruijn_counter`

## Requirements
- R1: With `rst` high at a clock edge, `state_q` becomes SEED (default 4'b0001) after that edge. Reset takes priority over `load` and `en`.
- R2: With `rst` and `load` low and `en` low, `state_q` keeps its value across the edge.
- R3: With `rst` low and `load` high, `state_q` takes the value of `seed_in` after the edge, whatever the value of `en`. Zero is a legal seed.
- R4: On an enabled step (`rst` and `load` low, `en` high), bits [WIDTH-2:0] of the next state equal bits [WIDTH-1:1] of the current state, so the contents shift one place to the right.
- R5: On an enabled step, the new bit [WIDTH-1] is the XOR of the tap stages and of a flag that is 1 when bits [WIDTH-1:1] are all zero. For WIDTH=4 the taps are bits 0 and 1 (polynomial x^4+x^3+1).
- R6: An enabled step takes state 0…01 to 0…00, and the next step takes 0…00 to 10…0. The counter never locks up at zero.
- R7: From any state, 2^WIDTH enabled steps visit every state exactly once and return to the starting state.
- R8: `serial_q` always equals `state_q[0]`. Over one period, the 2^WIDTH cyclic windows of WIDTH consecutive `serial_q` samples are all distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to SEED |
| en | input | 1 | Step enable; low holds the state |
| load | input | 1 | Load `seed_in` into the register |
| seed_in | input | WIDTH | Value used by a load |
| state_q | output | WIDTH | Counter state; bit WIDTH-1 is the leftmost (entry) stage |
| serial_q | output | 1 | Rightmost stage, the serial sequence output |

## Verification
The assertions check on every cycle that the priority among reset, load, hold and step is obeyed, that an enabled step shifts the lower bits to the right, and that the splice from 0…01 through zero to 10…0 happens. Some properties cover a whole period and cannot be seen in a single cycle: that each state appears once per period, that the period is exactly 2^WIDTH, and that the serial windows are unique and cover every value. The bench shows these through full-period sweeps at widths 4 and 5. At width 4 it also compares each step against an independently computed next state.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    // Action taken by the state register at a clock edge, in priority order.
    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_HOLD  = 2'd3
    } step_op_e;

    // Inputs that decide the register action, kept together.
    typedef struct packed {
        logic rst;
        logic load;
        logic en;
    } ctrl_t;

    // Select the action: reset over load over step over hold.
    function automatic step_op_e select_op(input ctrl_t c);
        if (c.rst)       return OP_RESET;
        else if (c.load) return OP_LOAD;
        else if (c.en)   return OP_STEP;
        else             return OP_HOLD;
    endfunction

    // Tap mask for a right-shifting Fibonacci register. Bit i set means that
    // stage i (0 = rightmost, oldest) takes part in the linear feedback.
    // Each mask is a primitive polynomial, so the plain register has the
    // maximal 2^w-1 cycle.
    function automatic logic [31:0] tap_mask(input int unsigned w);
        case (w)
            2:       return 32'h0000_0003;
            3:       return 32'h0000_0003;
            4:       return 32'h0000_0003;
            5:       return 32'h0000_0005;
            6:       return 32'h0000_0003;
            7:       return 32'h0000_0003;
            8:       return 32'h0000_001D;
            9:       return 32'h0000_0011;
            10:      return 32'h0000_0009;
            11:      return 32'h0000_0005;
            15:      return 32'h0000_0003;
            16:      return 32'h0000_100B;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/dbc_tap_xor.sv
// Linear part of the feedback: XOR of the stages selected by TAPS.
module dbc_tap_xor #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] TAPS = 4'b0011
) (
    input  logic [WIDTH-1:0] state,
    output logic             lin_bit
);
    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        if (TAPS[i]) begin : g_used
            assign chain[i+1] = chain[i] ^ state[i];
        end else begin : g_skip
            assign chain[i+1] = chain[i];
        end
    end

    assign lin_bit = chain[WIDTH];
endmodule

// File: rtl/dbc_zero_detect.sv
// Flags that every stage except the rightmost holds zero.
module dbc_zero_detect #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] state,
    output logic             upper_zero
);
    logic [WIDTH-1:0] any_set;

    assign any_set[0] = 1'b0;

    for (genvar i = 1; i < WIDTH; i++) begin : g_or
        assign any_set[i] = any_set[i-1] | state[i];
    end

    assign upper_zero = ~any_set[WIDTH-1];
endmodule

// File: rtl/dbc_shift_reg.sv
// State register: reset, load, right shift with new bit on the left, or hold.
module dbc_shift_reg
    import dbc_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] SEED = 4'b0001
) (
    input  logic             clk,
    input  ctrl_t            ctrl,
    input  logic [WIDTH-1:0] seed_in,
    input  logic             fb_bit,
    output logic [WIDTH-1:0] state
);
    step_op_e         op;
    logic [WIDTH-1:0] shifted;

    assign op      = select_op(ctrl);
    assign shifted = {fb_bit, state[WIDTH-1:1]};

    always_ff @(posedge clk) begin
        case (op)
            OP_RESET: state <= SEED;
            OP_LOAD:  state <= seed_in;
            OP_STEP:  state <= shifted;
            default:  state <= state;
        endcase
    end
endmodule

// File: rtl/debruijn_counter.sv
// Full-period counter: maximal-length shift register plus zero splice.
module debruijn_counter
    import dbc_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] seed_in,
    output logic [WIDTH-1:0] state_q,
    output logic             serial_q
);
    localparam logic [31:0]      TAP_FULL = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAPS     = TAP_FULL[WIDTH-1:0];

    ctrl_t ctrl;
    logic  lin_bit;
    logic  upper_zero;
    logic  fb_bit;

    assign ctrl = '{rst: rst, load: load, en: en};

    dbc_tap_xor #(.WIDTH(WIDTH), .TAPS(TAPS)) u_taps (
        .state   (state_q),
        .lin_bit (lin_bit)
    );

    dbc_zero_detect #(.WIDTH(WIDTH)) u_zdet (
        .state      (state_q),
        .upper_zero (upper_zero)
    );

    // The zero flag flips the feedback in exactly two states:
    // 0..01 -> 0..00 instead of 10..0, and 0..00 -> 10..0 instead of stuck.
    assign fb_bit = lin_bit ^ upper_zero;

    dbc_shift_reg #(.WIDTH(WIDTH), .SEED(SEED)) u_reg (
        .clk     (clk),
        .ctrl    (ctrl),
        .seed_in (seed_in),
        .fb_bit  (fb_bit),
        .state   (state_q)
    );

    assign serial_q = state_q[0];
endmodule

// File: rtl/debruijn_counter_chk.sv
module debruijn_counter_chk #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             load,
    input logic [WIDTH-1:0] seed_in,
    input logic [WIDTH-1:0] state_q
);
    localparam logic [WIDTH-1:0] LOW_ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] HIGH_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    // R1: the first cycle after reset shows the seed
    assert_reset_seed_R1: assert property (@(posedge clk)
        $fell(rst) |-> state_q == SEED);

    // R2: hold when neither loading nor enabled
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && !$past(en)) |-> $stable(state_q));

    // R3: load copies the seed input
    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load)) |-> state_q == $past(seed_in));

    // R4: an enabled step shifts right
    assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(en))
        |-> state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1]));

    // R6: the zero state is spliced in after 0..01
    assert_splice_in_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(en) && $past(state_q) == LOW_ONE)
        |-> state_q == '0);

    // R6: the zero state is left towards 10..0
    assert_splice_out_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(en) && $past(state_q) == '0)
        |-> state_q == HIGH_ONE);
endmodule

bind debruijn_counter debruijn_counter_chk #(.WIDTH(WIDTH), .SEED(SEED)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .load    (load),
    .seed_in (seed_in),
    .state_q (state_q)
);

// File: tb/debruijn_counter_test.sv
`timescale 1ns/1ps
module debruijn_counter_test;
    logic       clk = 1'b0;
    logic       rst, en, load;
    logic [3:0] seed_in;
    logic [3:0] state_q;
    logic       serial_q;
    logic [4:0] seed5;
    logic [4:0] state5;
    logic       serial5;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    debruijn_counter #(.WIDTH(4)) uut (
        .clk(clk), .rst(rst), .en(en), .load(load),
        .seed_in(seed_in), .state_q(state_q), .serial_q(serial_q)
    );

    debruijn_counter #(.WIDTH(5)) uut_w5 (
        .clk(clk), .rst(rst), .en(en), .load(load),
        .seed_in(seed5), .state_q(state5), .serial_q(serial5)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic r, input logic l, input logic e, input logic [3:0] s);
        @(negedge clk);
        rst = r; load = l; en = e; seed_in = s;
        @(posedge clk);
        #1;
    endtask

    // Next state from the requirement: shift right, new left bit is
    // s[0]^s[1]^(s[3:1]==0).
    function automatic logic [3:0] model_next(input logic [3:0] s);
        logic nb;
        nb = s[0] ^ s[1] ^ (s[3:1] == 3'b000);
        return {nb, s[3:1]};
    endfunction

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0]  prev;
        logic [15:0] seen;
        logic [15:0] sbits;
        logic [15:0] wseen;
        logic [31:0] seen5;
        int          dup;

        rst = 1'b1; load = 1'b0; en = 1'b0; seed_in = 4'h0; seed5 = 5'h0;
        step(1, 0, 0, 4'h0);
        step(1, 0, 1, 4'h0);
        check("R1 reset seed", {28'h0, state_q}, 32'h1);
        check("R8 serial after reset", {31'h0, serial_q}, 32'h1);

        // R2: hold with enable low
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 0, 4'hF);
            check("R2 hold", {28'h0, state_q}, 32'h1);
        end

        // Full period from 0001: R4, R5, R7, R8
        seen = '0; dup = 0;
        for (int i = 0; i < 16; i++) begin
            prev     = state_q;
            sbits[i] = serial_q;
            check("R8 serial equals stage 0", {31'h0, serial_q}, {31'h0, state_q[0]});
            if (seen[prev]) dup++;
            seen[prev] = 1'b1;
            step(0, 0, 1, 4'h0);
            check("R4 R5 step", {28'h0, state_q}, {28'h0, model_next(prev)});
        end
        check("R7 all states visited", {16'h0, seen}, 32'hFFFF);
        check("R7 no repeats", dup, 0);
        check("R7 returns to start", {28'h0, state_q}, 32'h1);

        // R8: cyclic windows of four serial samples
        wseen = '0; dup = 0;
        for (int t = 0; t < 16; t++) begin
            logic [3:0] w;
            w = {sbits[t], sbits[(t+1) % 16], sbits[(t+2) % 16], sbits[(t+3) % 16]};
            if (wseen[w]) dup++;
            wseen[w] = 1'b1;
        end
        check("R8 windows cover all", {16'h0, wseen}, 32'hFFFF);
        check("R8 windows distinct", dup, 0);

        // R6: splice around zero
        step(0, 1, 0, 4'h1);
        check("R3 load 0001", {28'h0, state_q}, 32'h1);
        step(0, 0, 1, 4'h0);
        check("R6 0001 to 0000", {28'h0, state_q}, 32'h0);
        step(0, 0, 1, 4'h0);
        check("R6 0000 to 1000", {28'h0, state_q}, 32'h8);

        // R3: load zero with enable low, then leave zero
        step(0, 1, 0, 4'h0);
        check("R3 load zero", {28'h0, state_q}, 32'h0);
        step(0, 0, 0, 4'h0);
        check("R2 hold zero", {28'h0, state_q}, 32'h0);
        step(0, 0, 1, 4'h0);
        check("R6 no lockup", {28'h0, state_q}, 32'h8);

        // R3: load wins over enable; reset wins over load
        step(0, 1, 1, 4'hA);
        check("R3 load over enable", {28'h0, state_q}, 32'hA);
        step(1, 1, 1, 4'h6);
        check("R1 reset over load", {28'h0, state_q}, 32'h1);

        // R7 at width 5: full period of 32 from the reset seed
        seen5 = '0; dup = 0;
        for (int i = 0; i < 32; i++) begin
            if (seen5[state5]) dup++;
            seen5[state5] = 1'b1;
            step(0, 0, 1, 4'h0);
        end
        check("R7 width5 all states", seen5, 32'hFFFF_FFFF);
        check("R7 width5 no repeats", dup, 0);
        check("R7 width5 back to seed", {27'h0, state5}, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule